// File: doc/BRIEF.md
# Per-Channel Quadrant Line-Noise Averager

This block sits after an integrating decimation filter that produces one conversion word at a time for eight interleaved input channels. Each channel is converted four times in every power-line cycle, once in each quarter of the cycle. The block keeps those four results apart, in a separate slot for each channel and quadrant. After every new result it emits the sum of the channel's four slots. A periodic 50 Hz or 60 Hz disturbance contributes equal and opposite amounts across the four quarters, so it cancels in the sum. The result matches integrating the input over one whole line period (20 ms or 16.67 ms). The upstream filter builds each conversion from 201 one-bit modulator samples at roughly 614 kHz, so results arrive at a slow and irregular rate compared with the clock.

A caller presents a result with a valid strobe, the channel number, the quadrant number and a bypass select. When bypass is low, the word is stored and the refreshed four-slot sum appears one clock later. When bypass is high, the word is forwarded unchanged, sign-extended, toward the calibration stage, and history is left alone. Output words are two bits wider than input words, so a sum of four extreme values always fits.

Top module: `lnr_quad_avg`

## Requirements
- R1: Each of the eight channels (channel index 0..7 on `in_chan`) has its own four slots. A write to one channel never changes the sum reported for any other channel.
- R2: A filtered sample (valid high, bypass low) overwrites only the slot selected by its channel and by quadrant index 0..3 on `in_quad`. The other three slots of that channel keep their values.
- R3: The filtered output is the two's-complement sum of the channel's four slots, with the new sample in its slot. Inputs are signed two's complement, and the sum is sign-extended to DW+2 bits without overflow, including when all four slots hold the most positive or the most negative input value.
- R4: Every emitted result appears exactly one clock after the input that caused it, and `out_chan` equals that input's channel.
- R5: A filtered sample for a channel produces no output pulse until every one of that channel's four quadrants has been written by a filtered sample since the last reset.
- R6: A bypass sample (valid high, bypass high) produces an output pulse one clock later whose word is the input word sign-extended to DW+2 bits. This holds whether or not the channel's history is full.
- R7: A bypass sample neither writes a slot nor counts toward a channel's quadrant fill.
- R8: Synchronous active-high reset clears every channel's fill state and drives `out_valid` low and `out_data`/`out_chan` to zero. Slot contents from before reset never reach the output.
- R9: With the four quadrant samples of a channel equal to a constant plus a four-phase term that sums to zero, the channel's filtered output is four times the constant.
- R10: In a cycle without an input strobe, or after a filtered sample that R5 suppresses, `out_valid` is low one clock later and `out_data` and `out_chan` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A conversion result is present this cycle |
| in_chan | input | 3 | Channel of the result |
| in_quad | input | 2 | Line-cycle quadrant of the result |
| in_data | input | 24 | Signed conversion result |
| in_bypass | input | 1 | Forward this result unfiltered |
| out_valid | output | 1 | One-cycle pulse marking a new output word |
| out_chan | output | 3 | Channel of the output word |
| out_data | output | 26 | Signed four-slot sum or sign-extended bypass word |

## Verification
The two functions that meet in one cycle are the slot write and the sum that must already include that write. The new word goes into memory at the same edge that registers the sum, so the sum has to take the incoming value in place of the stale slot. The bench provokes this by writing a channel's quadrant again in consecutive cycles with different values, and by completing a channel's fill with the very sample that first releases its output. A behavioural model, built from integer arrays, predicts valid, channel and word after every edge and is compared against the design on every clock. Any use of the stale slot shows up as a mismatch in the sum.

// File: rtl/lnr_pkg.sv
package lnr_pkg;

  // Which path feeds the registered output on a given sample.
  typedef enum logic [0:0] {
    PATH_FILTER = 1'b0,
    PATH_BYPASS = 1'b1
  } lnr_path_e;

endpackage

// File: rtl/lnr_hist_bank.sv
// One quadrant's slots for all channels: single write port, asynchronous
// read, no reset so it maps onto distributed RAM.
module lnr_hist_bank #(
  parameter int DW  = 24,
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           we,
  input  logic [CHW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [CHW-1:0] raddr,
  output logic [DW-1:0]  rdata
);

  logic [DW-1:0] mem [NCH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/lnr_fill_track.sv
// Per-channel record of which quadrants hold post-reset filtered data.
module lnr_fill_track #(
  parameter int NCH = 8,
  parameter int NQ  = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int QW  = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           upd,
  input  logic [CHW-1:0] chan,
  input  logic [QW-1:0]  quad,
  output logic           full_after
);

  logic [NQ-1:0] seen [NCH];
  logic [NQ-1:0] quad_bit;

  always_comb begin
    quad_bit = '0;
    quad_bit[quad] = 1'b1;
  end

  assign full_after = &(seen[chan] | quad_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        seen[i] <= '0;
      end
    end else if (upd) begin
      seen[chan] <= seen[chan] | quad_bit;
    end
  end

  // R5: an update leaves its quadrant marked as seen
  p_mark_set_r5: assert property (@(posedge clk) disable iff (rst)
    $past(upd) |-> seen[$past(chan)][$past(quad)]);

  // R8: fill state is empty on the first cycle after reset
  p_clear_after_reset_r8: assert property (@(posedge clk)
    $past(rst) |-> (seen[0] == '0));

endmodule

// File: rtl/lnr_sum_stage.sv
// Forms the four-slot sum (new word substituted for its own slot) or the
// bypass word, and registers the result.
module lnr_sum_stage
  import lnr_pkg::*;
#(
  parameter int DW  = 24,
  parameter int NCH = 8,
  parameter int NQ  = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int QW  = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int OW  = DW + QW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           in_bypass,
  input  logic [CHW-1:0] in_chan,
  input  logic [QW-1:0]  in_quad,
  input  logic [DW-1:0]  in_data,
  input  logic [NQ*DW-1:0] slots,
  input  logic           full_after,
  output logic           out_valid,
  output logic [CHW-1:0] out_chan,
  output logic [OW-1:0]  out_data
);

  lnr_path_e     path;
  logic [OW-1:0] sum_c;
  logic [OW-1:0] pass_c;
  logic          emit_c;

  assign path = in_bypass ? PATH_BYPASS : PATH_FILTER;

  always_comb begin
    logic [DW-1:0] term;
    sum_c = '0;
    for (int k = 0; k < NQ; k++) begin
      term = (in_quad == QW'(k)) ? in_data : slots[k*DW +: DW];
      sum_c = sum_c + {{QW{term[DW-1]}}, term};
    end
  end

  assign pass_c = {{QW{in_data[DW-1]}}, in_data};
  assign emit_c = in_valid && ((path == PATH_BYPASS) || full_after);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= emit_c;
      if (emit_c) begin
        out_chan <= in_chan;
        out_data <= (path == PATH_BYPASS) ? pass_c : sum_c;
      end
    end
  end

  // R6: bypass word leaves one cycle later, sign-extended
  p_bypass_pass_r6: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && in_bypass) |->
      (out_valid && $signed(out_data) == $signed($past(in_data))));

  // R5: a filtered sample on a partly filled channel emits nothing
  p_gate_unfilled_r5: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && !in_bypass && !full_after) |-> !out_valid);

  // R10: no strobe means no pulse and a held word
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    $past(!in_valid) |-> (!out_valid && $stable(out_data) && $stable(out_chan)));

endmodule

// File: rtl/lnr_quad_avg.sv
module lnr_quad_avg #(
  parameter int DW  = 24,
  parameter int NCH = 8,
  parameter int NQ  = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int QW  = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int OW  = DW + QW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [CHW-1:0] in_chan,
  input  logic [QW-1:0]  in_quad,
  input  logic [DW-1:0]  in_data,
  input  logic           in_bypass,
  output logic           out_valid,
  output logic [CHW-1:0] out_chan,
  output logic [OW-1:0]  out_data
);

  logic              store;
  logic [NQ*DW-1:0]  slots;
  logic              full_after;

  assign store = in_valid && !in_bypass;

  for (genvar q = 0; q < NQ; q++) begin : g_bank
    lnr_hist_bank #(.DW(DW), .NCH(NCH)) u_bank (
      .clk   (clk),
      .we    (store && (in_quad == QW'(q))),
      .waddr (in_chan),
      .wdata (in_data),
      .raddr (in_chan),
      .rdata (slots[q*DW +: DW])
    );
  end

  lnr_fill_track #(.NCH(NCH), .NQ(NQ)) u_fill (
    .clk        (clk),
    .rst        (rst),
    .upd        (store),
    .chan       (in_chan),
    .quad       (in_quad),
    .full_after (full_after)
  );

  lnr_sum_stage #(.DW(DW), .NCH(NCH), .NQ(NQ)) u_sum (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_bypass  (in_bypass),
    .in_chan    (in_chan),
    .in_quad    (in_quad),
    .in_data    (in_data),
    .slots      (slots),
    .full_after (full_after),
    .out_valid  (out_valid),
    .out_chan   (out_chan),
    .out_data   (out_data)
  );

  // R4: every output pulse follows an input strobe by one cycle
  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R4: the output carries the channel of the causing input
  p_chan_echo_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_chan == $past(in_chan)));

  // R8: output idle right after reset
  p_reset_idle_r8: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

endmodule

// File: tb/lnr_quad_avg_tb_top.sv
module lnr_quad_avg_tb_top;

  localparam int  DW      = 24;
  localparam int  NCH     = 8;
  localparam int  NQ      = 4;
  localparam int  OW      = DW + 2;
  localparam time CLK_PER = 10ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    in_chan = '0;
  logic [1:0]    in_quad = '0;
  logic [DW-1:0] in_data = '0;
  logic          in_bypass = 1'b0;
  logic          out_valid;
  logic [2:0]    out_chan;
  logic [OW-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;

  // behavioural reference state
  longint hist   [NCH][NQ];
  bit     filled [NCH][NQ];
  bit     e_valid;
  int     e_chan;
  longint e_data;

  always #(CLK_PER/2) clk = ~clk;

  lnr_quad_avg dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
    .in_quad(in_quad), .in_data(in_data), .in_bypass(in_bypass),
    .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data)
  );

  task automatic compare(string req);
    longint act;
    act = longint'($signed(out_data));
    n_chk++;
    if (out_valid !== e_valid || (e_valid && int'(out_chan) != e_chan) || act != e_data) begin
      n_bad++;
      $display("FAIL %s: act valid=%0b chan=%0d data=%0d exp valid=%0b chan=%0d data=%0d",
               req, out_valid, out_chan, act, e_valid, e_chan, e_data);
    end
  endtask

  // Drive one cycle of stimulus (called right after a falling edge),
  // advance the model at the rising edge, compare at the next falling edge.
  task automatic step(bit v, int c, int q, longint d, bit b, string req);
    longint sum;
    bit     full;
    in_valid  = v;
    in_chan   = 3'(c);
    in_quad   = 2'(q);
    in_data   = d[DW-1:0];
    in_bypass = b;
    @(posedge clk);
    e_valid = 1'b0;
    if (v) begin
      if (b) begin
        e_valid = 1'b1;
        e_chan  = c;
        e_data  = d;
      end else begin
        hist[c][q]   = d;
        filled[c][q] = 1'b1;
        full = 1'b1;
        sum  = 0;
        for (int k = 0; k < NQ; k++) begin
          full = full & filled[c][k];
          sum  = sum + hist[c][k];
        end
        if (full) begin
          e_valid = 1'b1;
          e_chan  = c;
          e_data  = sum;
        end
      end
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 1'b0, req);
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    for (int c = 0; c < NCH; c++)
      for (int q = 0; q < NQ; q++) filled[c][q] = 1'b0;
    e_valid = 1'b0;
    e_chan  = 0;
    e_data  = 0;
    @(negedge clk);
    rst = 1'b0;
    compare("R8 reset state");
  endtask

  function automatic longint wave(int c, int q);
    longint a, bb;
    a  = 40000 * (c + 1);
    bb = 7000 * (c + 3);
    case (q)
      0: return a;
      1: return bb;
      2: return -a;
      default: return -bb;
    endcase
  endfunction

  function automatic longint konst(int c);
    return 100000 * longint'(c) - 250000;
  endfunction

  initial begin : watchdog
    #(CLK_PER * 200000);
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad + 1);
    $finish;
  end

  initial begin : stim
    for (int c = 0; c < NCH; c++)
      for (int q = 0; q < NQ; q++) hist[c][q] = 0;
    @(negedge clk);
    do_reset();

    // R5/R9/R1: interleaved fill, constant plus zero-sum periodic term
    for (int q = 0; q < NQ; q++)
      for (int c = 0; c < NCH; c++)
        step(1'b1, c, q, konst(c) + wave(c, q), 1'b0, (q < 3) ? "R5 held off" : "R9 four times constant");

    // R2: second line cycle with shifted phase, running overwrite
    for (int q = 0; q < NQ; q++)
      for (int c = 0; c < NCH; c++)
        step(1'b1, c, q, konst(c) + wave(c, (q + 1) % 4), 1'b0, "R2 overwrite one slot");

    // R2/R3: same slot rewritten in consecutive cycles (write and sum coincide)
    step(1'b1, 3, 2, 12345, 1'b0, "R2 back-to-back write a");
    step(1'b1, 3, 2, -54321, 1'b0, "R2 back-to-back write b");
    step(1'b1, 3, 1, 777, 1'b0, "R3 sum after rewrite");

    // R1: channel 4 unaffected by channel 3 writes
    step(1'b1, 4, 0, hist[4][0], 1'b0, "R1 channel isolation");

    // R6/R7: bypass into a full channel, then a filtered resample
    step(1'b1, 2, 1, -3000000, 1'b1, "R6 bypass passthrough");
    step(1'b1, 2, 0, hist[2][0], 1'b0, "R7 bypass left history alone");
    step(1'b1, 2, 3, 8388607, 1'b1, "R6 bypass max value");

    // R10: idle hold
    idle(3, "R10 idle hold");

    // R3: extremes, no overflow
    for (int q = 0; q < NQ; q++) step(1'b1, 5, q, 8388607, 1'b0, "R3 max positive sum");
    for (int q = 0; q < NQ; q++) step(1'b1, 6, q, -8388608, 1'b0, "R3 max negative sum");

    // R8/R5: reset discards fill; pre-reset slots never show
    step(1'b1, 0, 0, 999999, 1'b0, "R8 pre-reset write");
    do_reset();
    step(1'b1, 0, 1, 11, 1'b0, "R5 after reset q1");
    step(1'b1, 0, 2, 22, 1'b0, "R5 after reset q2");
    step(1'b1, 0, 3, 33, 1'b0, "R5 after reset q3");
    step(1'b1, 1, 2, -5000, 1'b1, "R6 bypass on unfilled channel");
    step(1'b1, 0, 2, 44, 1'b1, "R7 bypass does not fill");
    step(1'b1, 0, 0, 44, 1'b0, "R8 sum uses only post-reset data");
    step(1'b1, 7, 0, 5, 1'b0, "R10 suppressed sample holds output");

    // random mix, model compared every cycle
    for (int i = 0; i < 600; i++) begin
      longint d;
      d = longint'($signed(24'($urandom)));
      step(($urandom % 5) != 0, int'($urandom % NCH), int'($urandom % NQ), d,
           ($urandom % 6) == 0, "R3 random traffic");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule